// File: doc/BRIEF.md
# External Trigger Conditioner

This block cleans up a raw external trigger pin and feeds it to a timer that starts on a trigger. The pin is first brought into the base clock domain through a short synchronizer. A glitch filter then samples it on a slow sampling tick. A new level is accepted only once the same value has been seen on three ticks in a row, so short spikes and chatter are rejected. The block then looks for the chosen active edge on the filtered level and holds the resulting trigger for a programmable number of base-clock cycles. It then emits a strobe that is one base-clock cycle wide.

The sampling tick runs at the base clock divided by 2 or 4. A single doubling control changes two things at once: it doubles the sampling period and halves the selected delay. A trigger that waits out its delay blocks further edges until its strobe has gone out. Dropping the enable discards such a pending trigger. Software is expected to park the pin at its inactive level before enabling: low when rising edges trigger, high when falling edges trigger.

Top module: `ext_trig_cond`

## Requirements
- R1: The sampling period P is 2 base-clock cycles when `samp_div4`=0 and 4 cycles when it is 1. `period_dbl`=1 doubles it, giving 4 or 8.
- R2: The filtered level takes a new value only on a sampling tick, and only after three consecutive ticks have seen that value. Every synchronized change of the pin restarts the tick divider and clears the run. At P=2, a pulse that lasts 5 cycles is dropped, a 6-cycle pulse is accepted, and a chattering pin that never holds for 6 cycles produces no strobe.
- R3: With `edge_fall`=0 only a low-to-high change of the filtered level triggers. With `edge_fall`=1 only a high-to-low change triggers. The opposite direction produces no strobe.
- R4: `dly_sel` selects the extra delay D: 00 gives 0 cycles, 01 gives 4, 10 gives 8 and 11 gives 16. When `period_dbl`=1 the nonzero values are halved, to 2, 4 and 8.
- R5: Number the rising clock edges from 0, starting with the first edge at which `trig_raw` already holds its new stable level. `trig_strobe` first rises just after edge 3P+3+D.
- R6: While `trig_en`=0 no strobe is produced. Dropping `trig_en` discards a trigger that is still waiting out its delay.
- R7: An active edge that arrives while a delayed trigger is pending is ignored. Once the pending strobe has been issued, the next edge is accepted again.
- R8: Every strobe is exactly one base-clock cycle wide.
- R9: During reset and right after it, `trig_strobe` is 0 and the filtered level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_raw | input | 1 | Raw external trigger pin, asynchronous |
| trig_en | input | 1 | Enables triggering; 0 ignores the pin and discards a pending trigger |
| edge_fall | input | 1 | 0: rising edge active, 1: falling edge active |
| samp_div4 | input | 1 | Sampling clock: 0 for base/2, 1 for base/4 |
| period_dbl | input | 1 | 1 doubles the sampling period and halves the delay |
| dly_sel | input | 2 | Delay select: none, 4, 8 or 16 base cycles |
| trig_strobe | output | 1 | One-cycle trigger strobe to the timer |

## Verification
The embedded properties watch three things on every cycle. The filtered level may move only on a sampling tick, and two ticks never fall on adjacent cycles. The strobe is never wider than one cycle and never appears in the cycle after the enable was low. A pending countdown steps down by one each cycle and is not reloaded by a new edge. The exact latency formula for each combination of sampling rate, doubling and delay code can only be shown by the bench scenarios. The same holds for the boundary between a rejected 5-cycle pulse and an accepted 6-cycle one, for the rejection of chatter and of the wrong edge direction, and for the discarding of a pending trigger when the enable drops.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;

  typedef enum logic [1:0] {
    DLY_NONE = 2'b00,
    DLY_X1   = 2'b01,
    DLY_X2   = 2'b10,
    DLY_X4   = 2'b11
  } dly_e;

  // log2 of the sampling period in base-clock cycles
  function automatic int period_log2(input int base_log2, input logic div4, input logic dbl);
    return base_log2 + int'(div4) + int'(dbl);
  endfunction

  // delay in base-clock cycles; doubling halves the nonzero settings
  function automatic int delay_cycles(input int unit_log2, input logic [1:0] sel, input logic dbl);
    if (sel == DLY_NONE) return 0;
    return 1 << (unit_log2 + int'(sel) - 1 - int'(dbl));
  endfunction

endpackage

// File: rtl/ext_trig_rst_sync.sv
module ext_trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ext_trig_sync.sv
module ext_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ext_trig_filter.sv
module ext_trig_filter
  import ext_trig_pkg::*;
#(
  parameter  int BASE_LOG2 = 1,
  parameter  int MATCH     = 3,
  localparam int DIV_W     = BASE_LOG2 + 2,
  localparam int RUN_W     = (MATCH > 1) ? $clog2(MATCH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic div4,
  input  logic dbl,
  output logic level
);

  logic             prev_q;
  logic [DIV_W-1:0] div_q, div_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             level_q, level_d;
  logic [DIV_W-1:0] period_m1;
  logic             chg;
  logic             tick;
  logic             differs;
  logic             run_full;

  always_comb begin
    period_m1 = DIV_W'((1 << period_log2(BASE_LOG2, div4, dbl)) - 1);
    chg       = (din != prev_q);
    tick      = (div_q >= period_m1);
    differs   = (prev_q != level_q);
    run_full  = (run_q == RUN_W'(MATCH - 1));
  end

  // tick divider restarts on every synchronized change of the pin
  always_comb begin
    if (chg || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_comb begin
    level_d = level_q;
    run_d   = run_q;
    if (tick && differs && run_full) begin
      level_d = prev_q;
      run_d   = '0;
    end else if (chg) begin
      run_d = '0;
    end else if (tick) begin
      if (differs) run_d = run_q + 1'b1;
      else         run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      div_q   <= '0;
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      prev_q  <= din;
      div_q   <= div_d;
      run_q   <= run_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;

  // R2
  level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> $past(tick));

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ext_trig_edge_delay.sv
module ext_trig_edge_delay
  import ext_trig_pkg::*;
#(
  parameter  int UNIT_LOG2 = 2,
  localparam int CNT_W     = UNIT_LOG2 + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic       en,
  input  logic       edge_fall,
  input  logic [1:0] dly_sel,
  input  logic       dbl,
  output logic       strobe
);

  logic             last_q;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_q, strobe_d;
  logic             act_edge;
  logic [CNT_W-1:0] dly_val;

  always_comb begin
    dly_val = CNT_W'(delay_cycles(UNIT_LOG2, dly_sel, dbl));
    if (edge_e'(edge_fall) == EDGE_FALL) act_edge = en && !level && last_q;
    else                                 act_edge = en && level && !last_q;
  end

  always_comb begin
    strobe_d = 1'b0;
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    if (!en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        strobe_d = 1'b1;
        busy_d   = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (act_edge && !strobe_q) begin
      if (dly_val == '0) begin
        strobe_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        cnt_d  = dly_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      last_q   <= level;
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe = strobe_q;

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  // R6
  no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !strobe_q);

  // R7
  pending_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en) |=> (strobe_q || (cnt_q == $past(cnt_q) - 1'b1)));

  // R4
  delay_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q != '0));

endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import ext_trig_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int MATCH_COUNT      = 3,
  parameter int SAMPLE_BASE_LOG2 = 1,
  parameter int DELAY_UNIT_LOG2  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_raw,
  input  logic       trig_en,
  input  logic       edge_fall,
  input  logic       samp_div4,
  input  logic       period_dbl,
  input  logic [1:0] dly_sel,
  output logic       trig_strobe
);

  logic rst_n_int;
  logic pin_sync;
  logic level_filt;

  ext_trig_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ext_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (trig_raw),
    .dout  (pin_sync)
  );

  ext_trig_filter #(
    .BASE_LOG2 (SAMPLE_BASE_LOG2),
    .MATCH     (MATCH_COUNT)
  ) u_filter (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_sync),
    .div4  (samp_div4),
    .dbl   (period_dbl),
    .level (level_filt)
  );

  ext_trig_edge_delay #(.UNIT_LOG2(DELAY_UNIT_LOG2)) u_edge_delay (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .level     (level_filt),
    .en        (trig_en),
    .edge_fall (edge_fall),
    .dly_sel   (dly_sel),
    .dbl       (period_dbl),
    .strobe    (trig_strobe)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |=> !trig_strobe);

endmodule

// File: tb/ext_trig_cond_tb.sv
`timescale 1ns/1ps
module ext_trig_cond_tb;

  logic       clk;
  logic       rst_n;
  logic       trig_raw;
  logic       trig_en;
  logic       edge_fall;
  logic       samp_div4;
  logic       period_dbl;
  logic [1:0] dly_sel;
  logic       trig_strobe;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  ext_trig_cond u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_raw    (trig_raw),
    .trig_en     (trig_en),
    .edge_fall   (edge_fall),
    .samp_div4   (samp_div4),
    .period_dbl  (period_dbl),
    .dly_sel     (dly_sel),
    .trig_strobe (trig_strobe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: [11] samp_div4, [10] period_dbl, [9:8] dly_sel, [7] edge_fall, [6:0] expected edge count 3P+4+D
  localparam int NVEC = 9;
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 1'b0, 7'd10},
    {1'b0, 1'b0, 2'd1, 1'b0, 7'd14},
    {1'b1, 1'b0, 2'd2, 1'b1, 7'd24},
    {1'b0, 1'b0, 2'd3, 1'b1, 7'd26},
    {1'b0, 1'b1, 2'd1, 1'b0, 7'd18},
    {1'b1, 1'b1, 2'd3, 1'b0, 7'd36},
    {1'b1, 1'b1, 2'd0, 1'b1, 7'd28},
    {1'b1, 1'b0, 2'd3, 1'b0, 7'd32},
    {1'b0, 1'b1, 2'd2, 1'b1, 7'd20}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; n counts rising edges, the first one is n=1
  task automatic watch(input int win, input int flip1, input int flip2,
                       output int first_n, output int cnt, output int maxw);
    int w;
    logic prev;
    w = 0; prev = 1'b0; first_n = 0; cnt = 0; maxw = 0;
    for (int n = 1; n <= win; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (trig_strobe) begin
        w++;
        if (!prev) begin
          cnt++;
          if (first_n == 0) first_n = n;
        end
        if (w > maxw) maxw = w;
      end else begin
        w = 0;
      end
      prev = trig_strobe;
      if (n == flip1 || n == flip2) trig_raw = ~trig_raw;
    end
  endtask

  task automatic settle(input logic div4, input logic dbl, input logic [1:0] dsel, input logic fall);
    int f, c, m;
    trig_en    = 1'b0;
    samp_div4  = div4;
    period_dbl = dbl;
    dly_sel    = dsel;
    edge_fall  = fall;
    trig_raw   = fall;
    watch(40, 0, 0, f, c, m);
    chk("R6", "strobe while disabled during settle", c, 0);
    trig_en = 1'b1;
    watch(4, 0, 0, f, c, m);
    chk("R6", "strobe right after enable", c, 0);
  endtask

  initial begin
    int f, c, m;
    rst_n = 1'b0; trig_raw = 1'b0; trig_en = 1'b0; edge_fall = 1'b0;
    samp_div4 = 1'b0; period_dbl = 1'b0; dly_sel = 2'd0;
    repeat (5) @(negedge clk);
    chk("R9", "strobe in reset", int'(trig_strobe), 0);
    rst_n = 1'b1;
    watch(10, 0, 0, f, c, m);
    chk("R9", "strobe after reset", c, 0);

    // vector table: latency, edge direction and width
    for (int i = 0; i < NVEC; i++) begin
      settle(VEC[i][11], VEC[i][10], VEC[i][9:8], VEC[i][7]);
      trig_raw = ~VEC[i][7];
      watch(70, 0, 0, f, c, m);
      chk("R3", $sformatf("vec %0d strobe count", i), c, 1);
      chk("R5", $sformatf("vec %0d latency (R1/R4)", i), f, int'(VEC[i][6:0]));
      chk("R8", $sformatf("vec %0d strobe width", i), m, 1);
    end

    // wrong direction: rising mode, falling change gives nothing
    settle(1'b0, 1'b0, 2'd0, 1'b0);
    trig_raw = 1'b1;
    watch(30, 0, 0, f, c, m);
    trig_raw = 1'b0;
    watch(40, 0, 0, f, c, m);
    chk("R3", "falling change in rising mode", c, 0);

    // glitch of 5 cycles at P=2 is dropped
    settle(1'b0, 1'b0, 2'd0, 1'b0);
    trig_raw = 1'b1;
    watch(40, 5, 0, f, c, m);
    chk("R2", "5-cycle pulse", c, 0);

    // pulse of 6 cycles is accepted with the usual latency
    trig_raw = 1'b1;
    watch(40, 6, 0, f, c, m);
    chk("R2", "6-cycle pulse count", c, 1);
    chk("R2", "6-cycle pulse latency", f, 10);

    // chatter: 3 high / 1 low repeated, then a steady high
    settle(1'b0, 1'b0, 2'd0, 1'b0);
    c = 0;
    for (int k = 0; k < 6; k++) begin
      int f2, c2, m2;
      trig_raw = 1'b1;
      watch(3, 0, 0, f2, c2, m2);
      c += c2;
      trig_raw = 1'b0;
      watch(1, 0, 0, f2, c2, m2);
      c += c2;
    end
    chk("R2", "chatter strobe count", c, 0);
    trig_raw = 1'b1;
    watch(40, 0, 0, f, c, m);
    chk("R2", "steady level after chatter", f, 10);

    // second edge while a 16-cycle delay is pending is ignored
    settle(1'b0, 1'b0, 2'd3, 1'b0);
    trig_raw = 1'b1;
    watch(80, 8, 15, f, c, m);
    chk("R7", "strobes with edge during pending delay", c, 1);
    chk("R7", "pending strobe latency", f, 26);
    trig_raw = 1'b0;
    watch(30, 0, 0, f, c, m);
    trig_raw = 1'b1;
    watch(60, 0, 0, f, c, m);
    chk("R7", "edge after strobe accepted", f, 26);

    // dropping enable discards the pending trigger
    settle(1'b0, 1'b0, 2'd3, 1'b0);
    trig_raw = 1'b1;
    watch(15, 0, 0, f, c, m);
    trig_en = 1'b0;
    watch(40, 0, 0, f, c, m);
    chk("R6", "pending trigger after disable", c, 0);

    // edge while disabled
    settle(1'b0, 1'b0, 2'd0, 1'b0);
    trig_en  = 1'b0;
    trig_raw = 1'b1;
    watch(40, 0, 0, f, c, m);
    chk("R6", "edge while disabled", c, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule